// File: doc/BRIEF.md
# Quad-Capable Serial Peripheral Master

This block is a synchronous serial master that runs one transaction at a time against a chosen peripheral. A transaction always opens with an eight-bit command shifted out on a single data line. It may then carry a number of data bytes. Those bytes move either one bit per clock or four bits per clock, in either direction. All four combinations of idle clock level and sampling phase are supported. The mode, the divisor and the target are chosen per transaction, so peripherals with different needs can share the same lines.

The host starts a transaction with a single-cycle request that carries the mode, the target select, the command, the byte count, the direction, the lane width and the clock divisor. Write data is presented on a byte input and held until the master acknowledges it. Read data appears on a byte output with a one-cycle valid strobe. The four data lines are brought out as separate output, output-enable and input vectors, so the pads or a bench can resolve them.

Top module: `qspi_xfer_master`

## Requirements
- R1: While a chip select is asserted and no clock edge is due, `sclk` rests at the requested CPOL level (0 low, 1 high). `sclk` never changes while the block is idle, except in the cycle a new transaction asserts its chip select.
- R2: After reset, all `cs_n` are high, `busy` is low, `io_oe` is 0000, and `tx_ack` and `rx_valid` are low.
- R3: During a transaction, exactly the `cs_n` bit indexed by the requested select is low and every other bit is high. When idle, all bits are high.
- R4: The command byte is sent most significant bit first on `io_out[0]`. It is valid on the sampling edges: rising edges for modes 0 and 3, falling edges for modes 1 and 2 (mode = {CPOL, CPHA}).
- R5: With CPHA=0, `io_out[0]` carries command bit 7 from the cycle in which chip select asserts.
- R6: Every half period of `sclk` lasts `req_div`+1 system cycles. A transaction has 2×(8+8×len) edges in one-lane mode and 2×(8+2×len) edges in four-lane mode.
- R7: Chip select is asserted exactly `req_div`+1 cycles before the first clock edge, and is released exactly `req_div`+1 cycles after the last one.
- R8: In a four-lane write, each clock carries one nibble on `io_out[3:0]`, high nibble first, with nibble bit 3 on line 3, and `io_oe` is 1111.
- R9: In one-lane data, written bytes go out most significant bit first on `io_out[0]`. Read bytes are captured most significant bit first from `io_in[1]`.
- R10: In a four-lane read, `io_oe` is 0000 at every sampling edge of the data phase. Each received byte is the first captured nibble (high) followed by the second.
- R11: `tx_ack` pulses once for each write byte taken, and `tx_data` must then move to the next byte. `rx_valid` pulses once for each read byte. Neither pulses on the other direction.
- R12: A `req_start` raised while `busy` is high is ignored: it changes neither the running transaction nor anything after it.
- R13: With a length of 0, only the eight command clocks run, and neither `tx_ack` nor `rx_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Start pulse; taken only while idle |
| req_cpol | input | 1 | Idle clock level |
| req_cpha | input | 1 | 0: sample on first edge, 1: sample on second edge |
| req_sel | input | CS_W | Index of the chip select to assert |
| req_cmd | input | 8 | Command byte |
| req_len | input | LEN_W | Number of data bytes after the command |
| req_read | input | 1 | 1: data phase reads, 0: data phase writes |
| req_quad | input | 1 | 1: data phase uses four lines |
| req_div | input | DIV_W | Half period in system cycles, minus one |
| busy | output | 1 | Transaction in progress |
| tx_data | input | 8 | Next write byte, held until acknowledged |
| tx_ack | output | 1 | Write byte consumed |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | `rx_data` updated this cycle |
| sclk | output | 1 | Serial clock |
| cs_n | output | NUM_CS | Active-low chip selects |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The bench acts as a peripheral for every mode, with lengths from zero to three bytes and divisors 0 and 2, in command-only, one-lane and four-lane transfers in both directions. It samples only on the edge that the mode table names. A master that sampled or launched on the wrong edge would therefore deliver bits shifted by one position. A master that drove the first CPHA=0 bit late would fail the check made in the chip-select cycle. A master that released the data lines one slot late in a four-lane read would be seen driving against the peripheral on its first sampling edge. The bench also times every half period and both chip-select margins, so an off-by-one divisor or a missing setup slot is reported. A second start pulse sent mid-transfer would show up as a corrupted command or a stray transaction.

// File: rtl/qspi_pkg.sv
// Shared types for the serial master: transaction phases and fixed widths.
package qspi_pkg;

    // Sequencer phases of one transaction.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_RUN   = 2'd2,
        PH_HOLD  = 2'd3
    } phase_t;

    // Width of the command and of every data byte.
    localparam int BYTE_BITS = 8;
    // Number of data lines.
    localparam int LANES = 4;

endpackage

// File: rtl/qspi_half_timer.sv
// Half-period timer: while run is high, it emits a tick once every div+1 cycles.
// Assumes div is held steady for as long as run is high.
module qspi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Count system cycles inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == div);

endmodule

// File: rtl/qspi_seq.sv
// Transaction sequencer. It walks setup, clocked run and hold, toggles the
// serial clock on each tick of the run, and derives the launch and sample
// events of every clock slot from the phase setting.
// Assumes last_slot and cpha are stable from the cycle after start.
module qspi_seq
    import qspi_pkg::*;
#(
    parameter int SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_cpol,
    input  logic              tick,
    input  logic              cpha,
    input  logic [SLOT_W-1:0] last_slot,
    output phase_t            phase,
    output logic              sclk,
    output logic              drive_adv,
    output logic              sample,
    output logic [SLOT_W-1:0] slot,
    output logic              done
);

    localparam int EDGE_W = SLOT_W + 1;

    logic [EDGE_W-1:0] edge_cnt;
    logic              edge_fire;
    logic              lead;
    logic              last_edge;

    assign edge_fire = tick && (phase == PH_SETUP || phase == PH_RUN);
    assign lead      = ~edge_cnt[0];
    assign slot      = edge_cnt[EDGE_W-1:1];
    assign last_edge = (slot == last_slot) && !lead;

    // Launch the next bit: on trailing edges for CPHA=0, on leading edges for CPHA=1.
    assign drive_adv = edge_fire &&
                       (cpha ? (lead && slot != '0) : (!lead && slot != last_slot));
    // Capture: on leading edges for CPHA=0, on trailing edges for CPHA=1.
    assign sample    = edge_fire && (cpha ? !lead : lead);
    assign done      = tick && (phase == PH_HOLD);

    // Advance the phase and the edge count, and toggle the clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            sclk     <= 1'b0;
            edge_cnt <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_SETUP;
                        sclk     <= start_cpol;
                        edge_cnt <= '0;
                    end
                end
                PH_SETUP: begin
                    if (tick) begin
                        phase    <= PH_RUN;
                        sclk     <= ~sclk;
                        edge_cnt <= edge_cnt + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (tick) begin
                        sclk     <= ~sclk;
                        edge_cnt <= edge_cnt + 1'b1;
                        if (last_edge) begin
                            phase <= PH_HOLD;
                        end
                    end
                end
                PH_HOLD: begin
                    if (tick) begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/qspi_tx_lane.sv
// Output shifter. The command is loaded at start and sent one bit per slot on
// line 0. Data bytes follow, one bit or one nibble per slot. It also owns the
// output enables and acknowledges each write byte it takes.
// Assumes tx_data holds the next byte until tx_ack is seen.
module qspi_tx_lane
    import qspi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [BYTE_BITS-1:0] start_cmd,
    input  logic                 adv,
    input  logic                 done,
    input  logic                 quad,
    input  logic                 read,
    input  logic [BYTE_BITS-1:0] tx_data,
    output logic [LANES-1:0]     io_out,
    output logic [LANES-1:0]     io_oe,
    output logic                 tx_ack
);

    logic [BYTE_BITS-1:0] sr;
    logic [3:0]           rem;
    logic                 wide;
    logic [LANES-1:0]     oe_q;
    logic                 ack_q;
    logic [3:0]           step;

    assign step = wide ? 4'd4 : 4'd1;

    // Shift within a byte, or fetch the next byte when the current one is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr    <= '0;
            rem   <= '0;
            wide  <= 1'b0;
            oe_q  <= '0;
            ack_q <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (start) begin
                sr   <= start_cmd;
                rem  <= 4'd8;
                wide <= 1'b0;
                oe_q <= 4'b0001;
            end else if (done) begin
                sr   <= '0;
                wide <= 1'b0;
                oe_q <= '0;
            end else if (adv) begin
                if (rem > step) begin
                    sr  <= wide ? {sr[3:0], 4'b0000} : {sr[6:0], 1'b0};
                    rem <= rem - step;
                end else begin
                    sr    <= read ? '0 : tx_data;
                    rem   <= 4'd8;
                    wide  <= quad;
                    oe_q  <= !quad ? 4'b0001 : (read ? 4'b0000 : 4'b1111);
                    ack_q <= !read;
                end
            end
        end
    end

    assign io_out = wide ? sr[7:4] : {3'b000, sr[7]};
    assign io_oe  = oe_q;
    assign tx_ack = ack_q;

endmodule

// File: rtl/qspi_rx_lane.sv
// Input assembler. It collects data-phase samples, one bit from line 1 or one
// nibble from all four lines, and emits each completed byte with a strobe.
// Assumes sample fires only on capture edges and in_data marks data slots.
module qspi_rx_lane
    import qspi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 sample,
    input  logic                 in_data,
    input  logic                 quad,
    input  logic                 read,
    input  logic [LANES-1:0]     io_in,
    output logic [BYTE_BITS-1:0] rx_data,
    output logic                 rx_valid
);

    logic [BYTE_BITS-1:0] sr;
    logic [3:0]           cnt;
    logic [BYTE_BITS-1:0] sr_next;
    logic [3:0]           cnt_next;

    assign sr_next  = quad ? {sr[3:0], io_in} : {sr[6:0], io_in[1]};
    assign cnt_next = cnt + (quad ? 4'd4 : 4'd1);

    // Accumulate read samples and present each full byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            cnt      <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (start) begin
                cnt <= '0;
            end else if (sample && in_data && read) begin
                sr <= sr_next;
                if (cnt_next == 4'd8) begin
                    rx_data  <= sr_next;
                    rx_valid <= 1'b1;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt_next;
                end
            end
        end
    end

endmodule

// File: rtl/qspi_xfer_master.sv
// Serial master top. It latches a request, times the clock, decodes the chip
// selects and wires the output shifter and the input assembler.
// Assumes requests are single-cycle pulses and are ignored while busy.
module qspi_xfer_master
    import qspi_pkg::*;
#(
    parameter int  NUM_CS = 4,
    parameter int  LEN_W  = 4,
    parameter int  DIV_W  = 8,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_start,
    input  logic                 req_cpol,
    input  logic                 req_cpha,
    input  logic [CS_W-1:0]      req_sel,
    input  logic [7:0]           req_cmd,
    input  logic [LEN_W-1:0]     req_len,
    input  logic                 req_read,
    input  logic                 req_quad,
    input  logic [DIV_W-1:0]     req_div,
    output logic                 busy,
    input  logic [7:0]           tx_data,
    output logic                 tx_ack,
    output logic [7:0]           rx_data,
    output logic                 rx_valid,
    output logic                 sclk,
    output logic [NUM_CS-1:0]    cs_n,
    output logic [3:0]           io_out,
    output logic [3:0]           io_oe,
    input  logic [3:0]           io_in
);

    localparam int MAX_SLOTS = BYTE_BITS * (1 << LEN_W);
    localparam int SLOT_W    = $clog2(MAX_SLOTS);

    phase_t            phase;
    logic              start;
    logic              tick;
    logic              drive_adv;
    logic              sample;
    logic              done;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] last_slot;
    logic              in_data;

    logic              cfg_cpha;
    logic              cfg_read;
    logic              cfg_quad;
    logic [CS_W-1:0]   cfg_sel;
    logic [LEN_W-1:0]  cfg_len;
    logic [DIV_W-1:0]  cfg_div;

    assign start = req_start && (phase == PH_IDLE);
    assign busy  = (phase != PH_IDLE);

    // Hold the request settings for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_cpha <= 1'b0;
            cfg_read <= 1'b0;
            cfg_quad <= 1'b0;
            cfg_sel  <= '0;
            cfg_len  <= '0;
            cfg_div  <= '0;
        end else if (start) begin
            cfg_cpha <= req_cpha;
            cfg_read <= req_read;
            cfg_quad <= req_quad;
            cfg_sel  <= req_sel;
            cfg_len  <= req_len;
            cfg_div  <= req_div;
        end
    end

    // Index of the final slot: the command slots plus the data slots, minus one.
    assign last_slot = SLOT_W'(BYTE_BITS - 1) +
                       (cfg_quad ? (SLOT_W'(cfg_len) << 1) : (SLOT_W'(cfg_len) << 3));
    assign in_data   = (slot >= SLOT_W'(BYTE_BITS));

    qspi_half_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (cfg_div),
        .tick  (tick)
    );

    qspi_seq #(
        .SLOT_W (SLOT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_cpol (req_cpol),
        .tick       (tick),
        .cpha       (cfg_cpha),
        .last_slot  (last_slot),
        .phase      (phase),
        .sclk       (sclk),
        .drive_adv  (drive_adv),
        .sample     (sample),
        .slot       (slot),
        .done       (done)
    );

    qspi_tx_lane u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_cmd (req_cmd),
        .adv       (drive_adv),
        .done      (done),
        .quad      (cfg_quad),
        .read      (cfg_read),
        .tx_data   (tx_data),
        .io_out    (io_out),
        .io_oe     (io_oe),
        .tx_ack    (tx_ack)
    );

    qspi_rx_lane u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sample   (sample),
        .in_data  (in_data),
        .quad     (cfg_quad),
        .read     (cfg_read),
        .io_in    (io_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    // One active-low select per target; only the latched index goes low.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !(busy && (cfg_sel == CS_W'(g)));
    end

endmodule

// File: rtl/qspi_xfer_master_chk.sv
// Protocol checker for the serial master, attached to every instance by bind.
module qspi_xfer_master_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_start,
    input logic              busy,
    input logic              sclk,
    input logic [NUM_CS-1:0] cs_n,
    input logic [3:0]        io_oe,
    input logic              tx_ack,
    input logic              rx_valid
);

    // R3
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R3
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n));

    // R1
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> $stable(sclk));

    // R8
    oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b1111));

    // R11
    ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> busy);

    // R11
    rx_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);

    // R12
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_start));

endmodule

bind qspi_xfer_master qspi_xfer_master_chk #(
    .NUM_CS (NUM_CS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .busy      (busy),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .io_oe     (io_oe),
    .tx_ack    (tx_ack),
    .rx_valid  (rx_valid)
);

// File: tb/test_qspi_xfer_master.sv
// Bench: plays a peripheral for every mode, direction and lane width.
module test_qspi_xfer_master;

    localparam int NUM_CS = 4;
    localparam int LEN_W  = 4;
    localparam int DIV_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_start;
    logic             req_cpol;
    logic             req_cpha;
    logic [1:0]       req_sel;
    logic [7:0]       req_cmd;
    logic [LEN_W-1:0] req_len;
    logic             req_read;
    logic             req_quad;
    logic [DIV_W-1:0] req_div;
    logic             busy;
    logic [7:0]       tx_data;
    logic             tx_ack;
    logic [7:0]       rx_data;
    logic             rx_valid;
    logic             sclk;
    logic [3:0]       cs_n;
    logic [3:0]       io_out;
    logic [3:0]       io_oe;
    logic [3:0]       io_in;

    int vectors     = 0;
    int miscompares = 0;
    int cycles      = 0;
    bit finished    = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    qspi_xfer_master #(
        .NUM_CS (NUM_CS),
        .LEN_W  (LEN_W),
        .DIV_W  (DIV_W)
    ) i_qspi_xfer_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_start (req_start),
        .req_cpol  (req_cpol),
        .req_cpha  (req_cpha),
        .req_sel   (req_sel),
        .req_cmd   (req_cmd),
        .req_len   (req_len),
        .req_read  (req_read),
        .req_quad  (req_quad),
        .req_div   (req_div),
        .busy      (busy),
        .tx_data   (tx_data),
        .tx_ack    (tx_ack),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .io_out    (io_out),
        .io_oe     (io_oe),
        .io_in     (io_in)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wr_byte(input int c, input int i);
        return 8'((c * 3 + i * 41 + 7) & 255);
    endfunction

    function automatic logic [7:0] rd_byte(input int c, input int i);
        return 8'((c ^ (i * 29 + 150)) & 255);
    endfunction

    // kind: 0 command only, 1 one-lane write, 2 one-lane read, 3 four-lane write, 4 four-lane read
    task automatic run_xfer(input int mode, input int kind, input int div);
        int         len;
        int         sel;
        int         cmd;
        int         slots;
        int         cyc       = 0;
        int         last_evt  = 0;
        int         edges     = 0;
        int         samples   = 0;
        int         acks      = 0;
        int         rxn       = 0;
        int         wbits     = 0;
        int         wbytes    = 0;
        int         cs_bad    = 0;
        bit         cpol;
        bit         cpha;
        bit         rd;
        bit         qd;
        bit         prev_sclk;
        bit         fin       = 1'b0;
        logic [7:0] got_cmd   = '0;
        logic [7:0] wcur      = '0;
        logic [7:0] b;
        logic [3:0] exp_cs;
        cpol  = mode[1];
        cpha  = mode[0];
        rd    = (kind == 2) || (kind == 4);
        qd    = (kind == 3) || (kind == 4);
        len   = (kind == 0) ? 0 : 1 + ((mode + kind + div) % 3);
        sel   = (mode + kind) % 4;
        cmd   = (mode * 53 + kind * 17 + div * 5 + 60) & 255;
        slots = 8 + (qd ? 2 * len : 8 * len);
        exp_cs = ~(4'b0001 << sel);

        @(negedge clk);
        req_cpol  = cpol;
        req_cpha  = cpha;
        req_sel   = 2'(sel);
        req_cmd   = 8'(cmd);
        req_len   = LEN_W'(len);
        req_read  = rd;
        req_quad  = qd;
        req_div   = DIV_W'(div);
        tx_data   = wr_byte(cmd, 0);
        io_in     = 4'h5;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        check("R3 select asserted", int'(cs_n), int'(exp_cs));
        check("R1 clock rests at CPOL after select", int'(sclk), int'(cpol));
        if (!cpha) check("R5 first command bit before first edge", int'(io_out[0]), int'(cmd[7]));
        prev_sclk = sclk;

        while (!fin && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            // R12: a second request in mid-transfer must be ignored
            if (cyc == 2) begin
                req_start = 1'b1;
                req_cmd   = ~8'(cmd);
                req_sel   = 2'(sel ^ 1);
            end else if (cyc == 3) begin
                req_start = 1'b0;
            end
            if (tx_ack) begin
                acks++;
                tx_data = wr_byte(cmd, acks);
            end
            if (rx_valid) begin
                check(qd ? "R10 four-lane read byte" : "R9 one-lane read byte",
                      int'(rx_data), int'(rd_byte(cmd, rxn)));
                rxn++;
            end
            if (sclk != prev_sclk) begin
                bit smp;
                check(edges == 0 ? "R7 select setup" : "R6 half period", cyc - last_evt, div + 1);
                last_evt = cyc;
                smp = (mode == 0 || mode == 3) ? sclk : !sclk;
                if (smp) begin
                    if (samples < 8) begin
                        got_cmd = {got_cmd[6:0], io_out[0]};
                    end else if (rd) begin
                        if (qd) check("R10 lines released at data sample", int'(io_oe), 0);
                    end else begin
                        if (qd) begin
                            check("R8 four-lane enables", int'(io_oe), 15);
                            wcur  = {wcur[3:0], io_out};
                            wbits = wbits + 4;
                        end else begin
                            wcur  = {wcur[6:0], io_out[0]};
                            wbits = wbits + 1;
                        end
                        if (wbits == 8) begin
                            check(qd ? "R8 four-lane write byte" : "R9 one-lane write byte",
                                  int'(wcur), int'(wr_byte(cmd, wbytes)));
                            wbytes++;
                            wbits = 0;
                        end
                    end
                    samples++;
                end else begin
                    // peripheral launches the data of slot 'samples'
                    if (rd && samples >= 8) begin
                        int d;
                        d = samples - 8;
                        if (qd) begin
                            b = rd_byte(cmd, d / 2);
                            io_in = (d % 2 == 0) ? b[7:4] : b[3:0];
                        end else begin
                            b = rd_byte(cmd, d / 8);
                            io_in = {2'b10, b[7 - (d % 8)], ~b[7 - (d % 8)]};
                        end
                    end else begin
                        io_in = 4'h5;
                    end
                end
                edges++;
                prev_sclk = sclk;
            end
            if (&cs_n) begin
                check("R7 select hold", cyc - last_evt, div + 1);
                check("R1 clock rests at CPOL at release", int'(sclk), int'(cpol));
                fin = 1'b1;
            end else if (cs_n != exp_cs) begin
                cs_bad++;
            end
        end

        check("R3 select stable through transfer", cs_bad, 0);
        check("R4 command byte on line 0", int'(got_cmd), cmd);
        check(len == 0 ? "R13 command-only edge count" : "R6 edge count", edges, 2 * slots);
        check(len == 0 ? "R13 no write acks" : "R11 write acks", acks, rd ? 0 : len);
        check("R11 read strobes", rxn, rd ? len : 0);
        check("R11 write bytes seen", wbytes, rd ? 0 : len);

        begin
            int stray;
            stray = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (!(&cs_n) || busy) stray++;
            end
            check("R12 no transaction from ignored request", stray, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (cycles < 150000 && !finished) @(negedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R6 watchdog actual=%0d expected<%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        req_start = 1'b0;
        req_cpol  = 1'b0;
        req_cpha  = 1'b0;
        req_sel   = '0;
        req_cmd   = '0;
        req_len   = '0;
        req_read  = 1'b0;
        req_quad  = 1'b0;
        req_div   = '0;
        tx_data   = '0;
        io_in     = '0;
        repeat (3) @(negedge clk);
        check("R2 reset selects", int'(cs_n), 15);
        check("R2 reset busy", int'(busy), 0);
        check("R2 reset enables", int'(io_oe), 0);
        check("R2 reset strobes", int'({tx_ack, rx_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 5; k++) begin
                for (int d = 0; d < 2; d++) begin
                    run_xfer(m, k, d * 2);
                end
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule